// File: doc/BRIEF.md
# Kernel Entry and Trap Controller

This block holds the page-map base register of a processor and decides, cycle by cycle, whether control passes from the running code into the kernel. The two low bits of the base register are used as machine state. Bit 0 selects the privilege level and bit 1 enables interrupts. The remaining bits carry the physical address of the active page table, which is aligned to 4 bytes. Decode reports supervisor calls, with a gate number, and illegal or privileged operations. External logic raises interrupt requests. The controller picks the winning cause and answers in the same cycle with a redirect address and a return address for the stack. On the next clock edge it loads the kernel's base value, with kernel mode set and interrupts off.

Entry addresses come from a small table of gate registers, and the kernel's own base value comes from a separate register. Both are written by privileged operations. The kernel leaves by writing the base register with a user page-table address and bit 0 set. Any privileged operation attempted in user mode is turned into an illegal-instruction trap, and its write is discarded.

Top module: `priv_trap_unit`

## Requirements
- R1: After reset `base_out` is 0, so the block is in kernel mode with interrupts disabled. No redirect is raised while every request is low.
- R2: `base_out[0]` is the mode bit (0 kernel, 1 user). `priv_req` with no other request causes no redirect in kernel mode. In user mode it redirects to the illegal-instruction gate.
- R3: `base_out[1]` is the interrupt-enable bit. While it is 0, `irq_req` alone raises no redirect and leaves `base_out` unchanged.
- R4: A supervisor call redirects to the entry of SVC gate `svc_gate` and pushes `next_pc`.
- R5: `illegal_req` redirects to the illegal-instruction gate and pushes `cur_pc`.
- R6: In user mode, `wr_base_req` traps to the illegal gate and pushes `cur_pc`. The written value does not reach `base_out`.
- R7: An interrupt taken with bit 1 set redirects to the interrupt gate and pushes `next_pc`.
- R8: `redirect_valid` and `push_valid` rise in the same cycle as the winning request. On the following cycle `base_out` equals the kernel base register with bits 1:0 forced to 0.
- R9: Priority is fixed. An illegal trap, including a user-mode privileged attempt, wins over an SVC, and an SVC wins over an interrupt.
- R10: Gate index encoding is 0 to 3 for the SVC gates, 4 for the interrupt gate and 5 for the illegal gate. Gate writes and kernel-base writes take effect only in kernel mode. In user mode they trap and change nothing.
- R11: In kernel mode, with no trap, `wr_base_req` loads `wr_base_data` into `base_out` on the next cycle, all bits included.
- R12: An interrupt request still held in the cycle after an entry is not taken, because entry cleared the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cur_pc | input | XLEN | Address of the instruction being decoded |
| next_pc | input | XLEN | Address of the following instruction |
| svc_req | input | 1 | Supervisor call request |
| svc_gate | input | GATE_W | SVC gate number |
| irq_req | input | 1 | External interrupt pending |
| illegal_req | input | 1 | Decode found an illegal instruction |
| priv_req | input | 1 | Some other privileged operation is being executed |
| wr_base_req | input | 1 | Privileged write of the base register |
| wr_base_data | input | XLEN | Value for the base register |
| wr_gate_req | input | 1 | Privileged write of one gate entry |
| wr_gate_idx | input | IDX_W | Gate index, encoded as in R10 |
| wr_gate_data | input | XLEN | Gate entry address |
| wr_kbase_req | input | 1 | Privileged write of the kernel base register |
| wr_kbase_data | input | XLEN | Kernel page-map base value |
| redirect_valid | output | 1 | Take `redirect_pc` this cycle |
| redirect_pc | output | XLEN | Gate entry address |
| push_valid | output | 1 | Push `push_pc` onto the stack this cycle |
| push_pc | output | XLEN | Return address to save |
| base_out | output | XLEN | Page-map base register with mode and enable bits |

## Verification
The properties assume that decode raises at most one of the privileged write strobes in any cycle. They also assume that `cur_pc` and `next_pc` are stable while a request is high. The bench keeps to this by driving each request from a task that changes inputs only on the falling edge and then returns every strobe to zero. Combined requests are driven only in the priority tests, and those tests mix only trap causes, never two different writes.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_ILL  = 2'd1,
    CAUSE_SVC  = 2'd2,
    CAUSE_IRQ  = 2'd3
  } cause_e;

  localparam int MODE_BIT = 0;
  localparam int IE_BIT   = 1;

  // Fixed priority: illegal, then supervisor call, then interrupt (masked by enable)
  function automatic cause_e pick_cause(input logic ill, input logic svc,
                                        input logic irq, input logic ie);
    if (ill)            return CAUSE_ILL;
    else if (svc)       return CAUSE_SVC;
    else if (irq && ie) return CAUSE_IRQ;
    else                return CAUSE_NONE;
  endfunction

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import priv_trap_pkg::*;
(
  input  logic   user_mode,
  input  logic   irq_en,
  input  logic   illegal_req,
  input  logic   priv_any,
  input  logic   svc_req,
  input  logic   irq_req,
  output logic   priv_viol,
  output cause_e cause
);

  assign priv_viol = user_mode & priv_any;

  always_comb begin
    cause = pick_cause(illegal_req | priv_viol, svc_req, irq_req, irq_en);
  end

endmodule

// File: rtl/gate_table.sv
module gate_table
  import priv_trap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int N_SVC  = 4,
  localparam int NGATE  = N_SVC + 2,
  localparam int GATE_W = (N_SVC > 1) ? $clog2(N_SVC) : 1,
  localparam int IDX_W  = $clog2(NGATE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [XLEN-1:0]   wr_data,
  input  logic [GATE_W-1:0] svc_sel,
  input  cause_e            cause,
  output logic [XLEN-1:0]   entry_pc
);

  localparam int IRQ_IDX = N_SVC;
  localparam int ILL_IDX = N_SVC + 1;

  logic [XLEN-1:0] gates [NGATE];

  for (genvar g = 0; g < NGATE; g++) begin : g_gate
    logic [XLEN-1:0] entry_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  entry_q <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))     entry_q <= wr_data;
    end
    assign gates[g] = entry_q;
  end

  always_comb begin
    unique case (cause)
      CAUSE_SVC: entry_pc = gates[svc_sel];
      CAUSE_IRQ: entry_pc = gates[IRQ_IDX];
      CAUSE_ILL: entry_pc = gates[ILL_IDX];
      default:   entry_pc = '0;
    endcase
  end

endmodule

// File: rtl/base_reg_unit.sv
module base_reg_unit
  import priv_trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_take,
  input  logic            wr_base_en,
  input  logic [XLEN-1:0] wr_base_data,
  input  logic            wr_kbase_en,
  input  logic [XLEN-1:0] wr_kbase_data,
  output logic [XLEN-1:0] base_q
);

  logic [XLEN-1:0] kbase_q;

  // Value loaded on entry: kernel table address, kernel mode, interrupts off
  function automatic logic [XLEN-1:0] entry_value(input logic [XLEN-1:0] k);
    logic [XLEN-1:0] v;
    v           = k;
    v[MODE_BIT] = 1'b0;
    v[IE_BIT]   = 1'b0;
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          base_q <= '0;
    else if (trap_take)  base_q <= entry_value(kbase_q);
    else if (wr_base_en) base_q <= wr_base_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           kbase_q <= '0;
    else if (wr_kbase_en) kbase_q <= wr_kbase_data;
  end

endmodule

// File: rtl/priv_trap_unit.sv
module priv_trap_unit
  import priv_trap_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int N_SVC = 4,
  localparam int GATE_W = (N_SVC > 1) ? $clog2(N_SVC) : 1,
  localparam int IDX_W  = $clog2(N_SVC + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   next_pc,
  input  logic              svc_req,
  input  logic [GATE_W-1:0] svc_gate,
  input  logic              irq_req,
  input  logic              illegal_req,
  input  logic              priv_req,
  input  logic              wr_base_req,
  input  logic [XLEN-1:0]   wr_base_data,
  input  logic              wr_gate_req,
  input  logic [IDX_W-1:0]  wr_gate_idx,
  input  logic [XLEN-1:0]   wr_gate_data,
  input  logic              wr_kbase_req,
  input  logic [XLEN-1:0]   wr_kbase_data,
  output logic              redirect_valid,
  output logic [XLEN-1:0]   redirect_pc,
  output logic              push_valid,
  output logic [XLEN-1:0]   push_pc,
  output logic [XLEN-1:0]   base_out
);

  logic            user_mode;
  logic            irq_en;
  logic            priv_any;
  logic            priv_viol;
  logic            trap_take;
  logic            kwrite_ok;
  cause_e          cause;
  logic [XLEN-1:0] entry_pc;
  logic [XLEN-1:0] base_q;

  assign user_mode = base_q[MODE_BIT];
  assign irq_en    = base_q[IE_BIT];
  assign priv_any  = wr_base_req | wr_gate_req | wr_kbase_req | priv_req;

  trap_arbiter u_arb (
    .user_mode   (user_mode),
    .irq_en      (irq_en),
    .illegal_req (illegal_req),
    .priv_any    (priv_any),
    .svc_req     (svc_req),
    .irq_req     (irq_req),
    .priv_viol   (priv_viol),
    .cause       (cause)
  );

  assign trap_take = (cause != CAUSE_NONE);
  assign kwrite_ok = !user_mode && !trap_take;

  gate_table #(.XLEN(XLEN), .N_SVC(N_SVC)) u_gates (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_gate_req & kwrite_ok),
    .wr_idx   (wr_gate_idx),
    .wr_data  (wr_gate_data),
    .svc_sel  (svc_gate),
    .cause    (cause),
    .entry_pc (entry_pc)
  );

  base_reg_unit #(.XLEN(XLEN)) u_base (
    .clk           (clk),
    .rst_n         (rst_n),
    .trap_take     (trap_take),
    .wr_base_en    (wr_base_req & kwrite_ok),
    .wr_base_data  (wr_base_data),
    .wr_kbase_en   (wr_kbase_req & kwrite_ok),
    .wr_kbase_data (wr_kbase_data),
    .base_q        (base_q)
  );

  assign redirect_valid = trap_take;
  assign redirect_pc    = entry_pc;
  assign push_valid     = trap_take;
  assign push_pc        = (cause == CAUSE_ILL) ? cur_pc : next_pc;
  assign base_out       = base_q;

endmodule

// File: rtl/priv_trap_chk.sv
module priv_trap_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            illegal_req,
  input logic            svc_req,
  input logic            irq_req,
  input logic            priv_req,
  input logic            wr_base_req,
  input logic            wr_gate_req,
  input logic            wr_kbase_req,
  input logic [XLEN-1:0] cur_pc,
  input logic [XLEN-1:0] next_pc,
  input logic            redirect_valid,
  input logic [XLEN-1:0] push_pc,
  input logic [XLEN-1:0] base_out,
  input logic            trap_take
);

  logic any_priv;
  assign any_priv = wr_base_req | wr_gate_req | wr_kbase_req | priv_req;

  // R8
  entry_kernel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |=> (base_out[1:0] == 2'b00));

  // R5
  ill_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_req |-> (redirect_valid && push_pc == cur_pc));

  // R6
  user_priv_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (base_out[0] && any_priv) |-> (redirect_valid && push_pc == cur_pc));

  // R3
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !base_out[1] && !svc_req && !illegal_req && !any_priv)
      |-> !redirect_valid);

  // R4
  svc_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_req && !illegal_req && !(base_out[0] && any_priv))
      |-> (redirect_valid && push_pc == next_pc));

  // R11
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect_valid && !wr_base_req) |=> $stable(base_out));

endmodule

bind priv_trap_unit priv_trap_chk #(.XLEN(XLEN)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .illegal_req    (illegal_req),
  .svc_req        (svc_req),
  .irq_req        (irq_req),
  .priv_req       (priv_req),
  .wr_base_req    (wr_base_req),
  .wr_gate_req    (wr_gate_req),
  .wr_kbase_req   (wr_kbase_req),
  .cur_pc         (cur_pc),
  .next_pc        (next_pc),
  .redirect_valid (redirect_valid),
  .push_pc        (push_pc),
  .base_out       (base_out),
  .trap_take      (trap_take)
);

// File: tb/priv_trap_unit_tb.sv
`timescale 1ns/1ps
module priv_trap_unit_tb;

  localparam int XLEN = 32;
  localparam logic [31:0] KBASE_WR = 32'h0005_0003;
  localparam logic [31:0] ENTRY    = 32'h0005_0000;
  localparam logic [31:0] IRQ_GATE = 32'h0000_2000;
  localparam logic [31:0] ILL_GATE = 32'h0000_3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cur_pc, next_pc;
  logic        svc_req, irq_req, illegal_req, priv_req;
  logic [1:0]  svc_gate;
  logic        wr_base_req, wr_gate_req, wr_kbase_req;
  logic [31:0] wr_base_data, wr_gate_data, wr_kbase_data;
  logic [2:0]  wr_gate_idx;
  logic        redirect_valid, push_valid;
  logic [31:0] redirect_pc, push_pc, base_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  priv_trap_unit #(.XLEN(XLEN), .N_SVC(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .next_pc(next_pc),
    .svc_req(svc_req), .svc_gate(svc_gate), .irq_req(irq_req),
    .illegal_req(illegal_req), .priv_req(priv_req),
    .wr_base_req(wr_base_req), .wr_base_data(wr_base_data),
    .wr_gate_req(wr_gate_req), .wr_gate_idx(wr_gate_idx), .wr_gate_data(wr_gate_data),
    .wr_kbase_req(wr_kbase_req), .wr_kbase_data(wr_kbase_data),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .push_valid(push_valid), .push_pc(push_pc), .base_out(base_out)
  );

  function automatic logic [31:0] svc_entry(input int k);
    return 32'h0000_1000 + 32'(k) * 32'h10;
  endfunction

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic idle();
    svc_req = 0; irq_req = 0; illegal_req = 0; priv_req = 0; svc_gate = '0;
    wr_base_req = 0; wr_gate_req = 0; wr_kbase_req = 0;
    wr_base_data = '0; wr_gate_data = '0; wr_kbase_data = '0; wr_gate_idx = '0;
  endtask

  task automatic set_pc(input logic [31:0] pc);
    cur_pc = pc; next_pc = pc + 32'd4;
  endtask

  // Every task starts shortly after a falling edge
  task automatic kwr_base(input logic [31:0] v);
    wr_base_req = 1; wr_base_data = v;
    @(negedge clk); idle();
  endtask

  task automatic kwr_gate(input int idx, input logic [31:0] v);
    wr_gate_req = 1; wr_gate_idx = 3'(idx); wr_gate_data = v;
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    #1;
    check("R1 base after reset", base_out, 32'h0);
    check("R1 no redirect at rest", {31'b0, redirect_valid}, 32'h0);
  endtask

  task automatic t_setup();
    for (int k = 0; k < 4; k++) kwr_gate(k, svc_entry(k));
    kwr_gate(4, IRQ_GATE);
    kwr_gate(5, ILL_GATE);
    wr_kbase_req = 1; wr_kbase_data = KBASE_WR;
    @(negedge clk); idle();
  endtask

  task automatic t_irq_masked();
    set_pc(32'h80); irq_req = 1; #1;
    check("R3 masked irq no redirect", {31'b0, redirect_valid}, 32'h0);
    @(negedge clk); idle(); #1;
    check("R3 base unchanged", base_out, 32'h0);
  endtask

  task automatic t_kernel_priv();
    priv_req = 1; #1;
    check("R2 kernel priv no redirect", {31'b0, redirect_valid}, 32'h0);
    @(negedge clk); idle();
    kwr_base(32'h0008_0002); #1;
    check("R11 kernel base write", base_out, 32'h0008_0002);
  endtask

  task automatic t_irq_taken();
    set_pc(32'h100); irq_req = 1; #1;
    check("R7 irq redirect", {31'b0, redirect_valid}, 32'h1);
    check("R7 irq target", redirect_pc, IRQ_GATE);
    check("R7 irq push next", push_pc, 32'h104);
    check("R8 push_valid with redirect", {31'b0, push_valid}, 32'h1);
    @(negedge clk); #1;
    check("R8 entry base", base_out, ENTRY);
    check("R12 held irq not retaken", {31'b0, redirect_valid}, 32'h0);
    idle(); @(negedge clk);
  endtask

  task automatic t_svc();
    kwr_base(32'h0009_0001);
    set_pc(32'h200); svc_req = 1; svc_gate = 2'd2; #1;
    check("R4 svc target", redirect_pc, svc_entry(2));
    check("R4 svc push next", push_pc, 32'h204);
    @(negedge clk); idle(); #1;
    check("R8 svc entry base", base_out, ENTRY);
  endtask

  task automatic t_illegal();
    kwr_base(32'h0009_0001);
    set_pc(32'h300); illegal_req = 1; #1;
    check("R5 ill target", redirect_pc, ILL_GATE);
    check("R5 ill push cur", push_pc, 32'h300);
    @(negedge clk); idle(); #1;
    check("R5 ill entry base", base_out, ENTRY);
  endtask

  task automatic t_user_priv();
    kwr_base(32'h0009_0001);
    set_pc(32'h400); wr_base_req = 1; wr_base_data = 32'hDEAD_0000; #1;
    check("R6 user base write traps", redirect_pc, ILL_GATE);
    check("R6 push cur", push_pc, 32'h400);
    @(negedge clk); idle(); #1;
    check("R6 write discarded", base_out, ENTRY);
    kwr_base(32'h0009_0001);
    set_pc(32'h410); priv_req = 1; #1;
    check("R2 user priv traps", redirect_pc, ILL_GATE);
    @(negedge clk); idle();
    kwr_base(32'h0009_0001);
    wr_gate_req = 1; wr_gate_idx = 3'd0; wr_gate_data = 32'h0000_0BAD; #1;
    check("R10 user gate write traps", redirect_pc, ILL_GATE);
    @(negedge clk); idle();
    kwr_base(32'h0009_0001);
    wr_kbase_req = 1; wr_kbase_data = 32'h0777_0000; #1;
    check("R10 user kbase write traps", redirect_pc, ILL_GATE);
    @(negedge clk); idle(); #1;
    check("R10 kbase unchanged", base_out, ENTRY);
    svc_req = 1; svc_gate = 2'd0; #1;
    check("R10 gate 0 unchanged", redirect_pc, svc_entry(0));
    @(negedge clk); idle();
  endtask

  task automatic t_priority();
    kwr_base(32'h0009_0003);
    set_pc(32'h500); illegal_req = 1; svc_req = 1; svc_gate = 2'd1; irq_req = 1; #1;
    check("R9 ill beats svc target", redirect_pc, ILL_GATE);
    check("R9 ill beats svc push", push_pc, 32'h500);
    @(negedge clk); idle();
    kwr_base(32'h0009_0003);
    set_pc(32'h600); svc_req = 1; svc_gate = 2'd3; irq_req = 1; #1;
    check("R9 svc beats irq target", redirect_pc, svc_entry(3));
    check("R9 svc beats irq push", push_pc, 32'h604);
    @(negedge clk); idle(); #1;
    check("R8 ie cleared on entry", base_out, ENTRY);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(); set_pc(32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    @(negedge clk);
    t_setup();
    t_irq_masked();
    t_kernel_priv();
    t_irq_taken();
    t_svc();
    t_illegal();
    t_user_priv();
    t_priority();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule